// File: doc/BRIEF.md
# Mask-Based Unsigned Magnitude Comparator

This combinational block compares two unsigned words of a configurable width and raises one of three flags: the first operand is greater, the first operand is smaller, or the two are equal. It does not find the deciding bit with a one-hot priority encoder. Each side's bitwise wins are first turned into a "won" vector. Each won vector then becomes a mask of the positions above its most significant 1. The two masks are crossed, and the crossing is OR-reduced.

The mask is a suffix OR of the won vector, inverted. A parameter picks how this OR is built: a linear ripple chain, or a log-depth tree. Both produce the same mask. Place the block anywhere a single-cycle unsigned ordering decision is needed, and register its flags outside it as needed.

Top module: `mag_cmp`

## Requirements
- R1: For every input pair, exactly one of `a_gt_o`, `a_lt_o` and `a_eq_o` is 1.
- R2: `a_gt_o` is 1 exactly when `a_i` is larger than `b_i` read as unsigned integers.
- R3: `a_lt_o` is 1 exactly when `a_i` is smaller than `b_i` read as unsigned integers.
- R4: `a_eq_o` is 1 exactly when the two words match in every bit.
- R5: Bit k of the first operand's won vector is `a_i[k] & ~b_i[k]`, and bit k of the second operand's won vector is `~a_i[k] & b_i[k]`. The two won vectors never share a 1. A single win at bit 1 alone decides the result in favour of that side.
- R6: A mask has 1s in every position strictly above the most significant 1 of its won vector. It has 0s at that position and at every position below it, so the mask is a contiguous run of 1s starting at the MSB.
- R7: A won vector that is all zeros gives an all-ones mask. As a result, an operand with no winning bit is never reported as greater.
- R8: The ripple chain (`PREFIX_TREE` = 0) and the log-depth tree (`PREFIX_TREE` = 1) give identical flags for every input pair.
- R9: The extreme pairs decide correctly: all ones against all zeros, a difference only in the MSB, and a difference only in the LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| a_gt_o | output | 1 | First operand is greater |
| a_lt_o | output | 1 | First operand is smaller |
| a_eq_o | output | 1 | Operands are equal |

## Verification
The bench builds the block three times. Two copies at a width of 4 bits, one with each mask structure, are swept over all 256 operand pairs. This makes every possible leading-win position, including the all-zero won vectors, visible on both structures. The third copy uses the default 16-bit width and the tree structure. It takes a directed table of extreme and single-bit-difference pairs, then random pairs, so that leading wins near the MSB and LSB are reached at full width.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_GT = 2'b01,
    CMP_LT = 2'b10
  } cmp_res_e;

  // Flag triple {gt, lt, eq} for a decided result.
  function automatic logic [2:0] flags_of(cmp_res_e r);
    case (r)
      CMP_GT:  flags_of = 3'b100;
      CMP_LT:  flags_of = 3'b010;
      default: flags_of = 3'b001;
    endcase
  endfunction

  // Decide from the two crossing reductions.
  function automatic cmp_res_e decide(logic a_side_hit, logic b_side_hit);
    if (a_side_hit)      decide = CMP_GT;
    else if (b_side_hit) decide = CMP_LT;
    else                 decide = CMP_EQ;
  endfunction

endpackage

// File: rtl/mcmp_win.sv
module mcmp_win #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] a_win_o,
  output logic [WIDTH-1:0] b_win_o
);

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign a_win_o[k] = a_i[k] & ~b_i[k];
    assign b_win_o[k] = ~a_i[k] & b_i[k];
  end

  always_comb begin
    AST_WIN_DISJOINT: assert ((a_win_o & b_win_o) == '0) else $error("won vectors overlap"); // R5
  end

endmodule

// File: rtl/mcmp_mask.sv
module mcmp_mask #(
  parameter int WIDTH       = 16,
  parameter bit PREFIX_TREE = 1'b1
) (
  input  logic [WIDTH-1:0] win_i,
  output logic [WIDTH-1:0] mask_o
);

  if (PREFIX_TREE) begin : g_tree
    localparam int STAGES = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    logic [STAGES:0][WIDTH-1:0] lvl;
    assign lvl[0] = win_i;
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int DIST = 1 << s;
      for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        if (k + DIST < WIDTH) begin : g_pair
          assign lvl[s+1][k] = lvl[s][k] | lvl[s][k+DIST];
        end else begin : g_pass
          assign lvl[s+1][k] = lvl[s][k];
        end
      end
    end
    assign mask_o = ~lvl[STAGES];
  end else begin : g_ripple
    logic [WIDTH:0] seen;
    assign seen[WIDTH] = 1'b0;
    for (genvar k = WIDTH - 1; k >= 0; k--) begin : g_bit
      assign seen[k] = seen[k+1] | win_i[k];
    end
    assign mask_o = ~seen[WIDTH-1:0];
  end

  logic [WIDTH-1:0] mask_up;
  assign mask_up = {1'b1, mask_o[WIDTH-1:1]};

  always_comb begin
    AST_MASK_RUN:   assert ((mask_o & ~mask_up) == '0) else $error("mask not a top run"); // R6
    AST_MASK_CLEAR: assert ((mask_o & win_i) == '0) else $error("mask covers a win"); // R6
    AST_MASK_FULL:  assert ((win_i == '0) == (mask_o == '1)) else $error("empty win mask"); // R7
  end

endmodule

// File: rtl/mcmp_cross.sv
module mcmp_cross #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_mask_i,
  input  logic [WIDTH-1:0] b_mask_i,
  output logic             a_hit_o,
  output logic             b_hit_o
);

  logic [WIDTH-1:0] a_cross;
  logic [WIDTH-1:0] b_cross;

  assign a_cross = ~a_mask_i & b_mask_i;
  assign b_cross = a_mask_i & ~b_mask_i;
  assign a_hit_o = |a_cross;
  assign b_hit_o = |b_cross;

  always_comb begin
    AST_CROSS_EXCL: assert (!(a_hit_o && b_hit_o)) else $error("both crossings hit"); // R1
  end

endmodule

// File: rtl/mag_cmp.sv
module mag_cmp #(
  parameter int WIDTH       = 16,
  parameter bit PREFIX_TREE = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             a_gt_o,
  output logic             a_lt_o,
  output logic             a_eq_o
);
  import mcmp_pkg::*;

  logic [WIDTH-1:0] a_win, b_win;
  logic [WIDTH-1:0] a_mask, b_mask;
  logic             a_hit, b_hit;
  cmp_res_e         res;

  mcmp_win #(.WIDTH(WIDTH)) u_win (
    .a_i(a_i), .b_i(b_i), .a_win_o(a_win), .b_win_o(b_win)
  );

  mcmp_mask #(.WIDTH(WIDTH), .PREFIX_TREE(PREFIX_TREE)) u_a_mask (
    .win_i(a_win), .mask_o(a_mask)
  );

  mcmp_mask #(.WIDTH(WIDTH), .PREFIX_TREE(PREFIX_TREE)) u_b_mask (
    .win_i(b_win), .mask_o(b_mask)
  );

  mcmp_cross #(.WIDTH(WIDTH)) u_cross (
    .a_mask_i(a_mask), .b_mask_i(b_mask), .a_hit_o(a_hit), .b_hit_o(b_hit)
  );

  assign res = decide(a_hit, b_hit);
  assign {a_gt_o, a_lt_o, a_eq_o} = flags_of(res);

  always_comb begin
    AST_ONE_FLAG: assert ($countones({a_gt_o, a_lt_o, a_eq_o}) == 1) else $error("flag count"); // R1
    AST_GT_ORDER: assert (!a_gt_o || (a_i > b_i)) else $error("gt wrong"); // R2
    AST_LT_ORDER: assert (!a_lt_o || (a_i < b_i)) else $error("lt wrong"); // R3
    AST_EQ_MATCH: assert (a_eq_o == (a_i == b_i)) else $error("eq wrong"); // R4
  end

endmodule

// File: tb/mag_cmp_bench.sv
module mag_cmp_bench;

  localparam int W  = 16;
  localparam int WS = 4;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0]  a, b;
  logic          gt, lt, eq;
  logic [WS-1:0] sa, sb;
  logic          t_gt, t_lt, t_eq, r_gt, r_lt, r_eq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  mag_cmp #(.WIDTH(W), .PREFIX_TREE(1'b1)) u_mag_cmp (
    .a_i(a), .b_i(b), .a_gt_o(gt), .a_lt_o(lt), .a_eq_o(eq)
  );
  mag_cmp #(.WIDTH(WS), .PREFIX_TREE(1'b1)) u_small_tree (
    .a_i(sa), .b_i(sb), .a_gt_o(t_gt), .a_lt_o(t_lt), .a_eq_o(t_eq)
  );
  mag_cmp #(.WIDTH(WS), .PREFIX_TREE(1'b0)) u_small_ripple (
    .a_i(sa), .b_i(sb), .a_gt_o(r_gt), .a_lt_o(r_lt), .a_eq_o(r_eq)
  );

  // {a, b, expected {gt, lt, eq}}
  localparam logic [34:0] VEC [NV] = '{
    {16'hFFFF, 16'h0000, 3'b100},  // R9 all ones vs zeros
    {16'h0000, 16'hFFFF, 3'b010},  // R9
    {16'h8000, 16'h7FFF, 3'b100},  // R9 MSB-only decides
    {16'h7FFF, 16'h8000, 3'b010},  // R9
    {16'h1235, 16'h1234, 3'b100},  // R9 LSB-only difference
    {16'h1234, 16'h1235, 3'b010},  // R9
    {16'hA5A5, 16'hA5A5, 3'b001},  // R4
    {16'h0002, 16'h0000, 3'b100},  // R5 lone win at bit 1
    {16'h0000, 16'h0002, 3'b010},  // R5
    {16'h00F0, 16'h0F00, 3'b010},  // R6 leading win mid-word
    {16'h4000, 16'h3FFF, 3'b100},  // R6 lower wins ignored
    {16'h0000, 16'h0001, 3'b010}   // R7 empty first won vector
  };

  function automatic logic [2:0] ref_flags(logic [W-1:0] x, logic [W-1:0] y, int n);
    for (int i = n - 1; i >= 0; i--) begin
      if (x[i] != y[i]) return x[i] ? 3'b100 : 3'b010;
    end
    return 3'b001;
  endfunction

  task automatic check(string req, logic [2:0] got, logic [2:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b expected=%b (a=%h b=%h sa=%h sb=%h)", req, got, exp, a, b, sa, sb);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    a = '0; b = '0; sa = '0; sb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R4 reset-state equal", {gt, lt, eq}, 3'b001);
    check("R1 reset-state one flag", {2'b00, ($countones({gt, lt, eq}) == 1)}, 3'b001);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      a = VEC[v][34:19];
      b = VEC[v][18:3];
      #1;
      check("R9/R5/R6/R7 table", {gt, lt, eq}, VEC[v][2:0]);
    end

    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        @(negedge clk);
        sa = WS'(x);
        sb = WS'(y);
        #1;
        check("R2/R3/R4 tree sweep", {t_gt, t_lt, t_eq}, ref_flags(W'(x), W'(y), WS));
        check("R8 ripple sweep", {r_gt, r_lt, r_eq}, ref_flags(W'(x), W'(y), WS));
        check("R1 one flag", {2'b00, ($countones({t_gt, t_lt, t_eq}) == 1)}, 3'b001);
      end
    end

    for (int n = 0; n < 1500; n++) begin
      @(negedge clk);
      a = W'($urandom);
      b = (n % 4 == 0) ? a ^ W'(1 << (n % W)) : W'($urandom);
      #1;
      check("R2/R3 random", {gt, lt, eq}, ref_flags(a, b, W));
    end

    done = 1'b1;
    finish_run();
  end

endmodule